// File: doc/BRIEF.md
# Saturating-Add Issue Decode and Fault Check

This block sits beside the issue stage of a SIMD unit. It looks at one packed unsigned saturating-add instruction each clock. From the opcode byte it works out the lane size, and from the operand-size prefix it works out the operand width. It then decides which processor fault, if any, the instruction has to take. The fault decision uses the prefix bits, the floating-point control bits, the capability flag, the privilege level, the pending-exception flag and the low bits of the memory address.

The faults that can apply depend on the width. A 128-bit operation checks for the extended-state enable and for wide-SIMD support, and it checks 16-byte alignment of a memory operand. A 64-bit operation checks for a pending floating-point exception and, under user-level alignment checking, 8-byte alignment. When several faults apply, only the one of highest priority is reported.

All results are registered. Each output shows the decision for the inputs that were present at the previous rising clock edge.

Top module: `psat_issue_check`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `op_valid`=0, `lane_word`=0, `width_wide`=0 and `fault`=0.
- R2: Opcode 0xDC gives `op_valid`=1 with `lane_word`=0 (byte lanes), and opcode 0xDD gives `op_valid`=1 with `lane_word`=1 (word lanes). The result appears one clock after the inputs are sampled.
- R3: For a recognised opcode, `width_wide` is 1 (128-bit) when `pfx_opsize` is set and 0 (64-bit) when it is clear.
- R4: Any other opcode gives `op_valid`=0, `lane_word`=0, `width_wide`=0 and `fault`=0, whatever the other inputs are.
- R5: `fault` bit 0 (illegal instruction) is raised when `ctl_emulate` is 1 or `pfx_lock` is 1.
- R6: A 128-bit operation raises `fault` bit 0 when `ctl_ext_state` is 0 or `cap_wide_simd` is 0. A 64-bit operation ignores both inputs.
- R7: `fault` bit 1 (device not available) is raised when `ctl_lazy_fp` is 1.
- R8: `fault` bit 2 (floating-point pending) is raised for a 64-bit operation when `fp_exc_pend` is 1. It is never raised for a 128-bit operation.
- R9: `fault` bit 3 (protection) is raised for a 128-bit memory operand when `addr_lo[3:0]` is nonzero. It is never raised for a register operand or for a 64-bit operation.
- R10: `fault` bit 4 (alignment) is raised for a 64-bit memory operand only when `align_chk_en`=1, `cpl`=3 and `addr_lo[2:0]` is nonzero. A 128-bit operation never raises it.
- R11: At most one `fault` bit is set. When several conditions hold, the lowest-numbered bit wins (bit 0 has the highest priority, bit 4 the lowest).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_byte | input | 8 | Opcode byte |
| pfx_opsize | input | 1 | Operand-size prefix present (selects 128-bit) |
| pfx_lock | input | 1 | Bus-lock prefix present |
| ctl_lazy_fp | input | 1 | Lazy floating-point context-switch control bit |
| ctl_emulate | input | 1 | Floating-point emulation control bit |
| ctl_ext_state | input | 1 | OS extended-state save enable |
| cap_wide_simd | input | 1 | Wide SIMD integer support present |
| align_chk_en | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| fp_exc_pend | input | 1 | Floating-point exception pending |
| mem_op | input | 1 | Source operand is in memory |
| addr_lo | input | 4 | Low bits of the memory operand address |
| op_valid | output | 1 | Opcode recognised |
| lane_word | output | 1 | 1 = word lanes, 0 = byte lanes |
| width_wide | output | 1 | 1 = 128-bit, 0 = 64-bit |
| fault | output | 5 | One-hot fault: bit 0 illegal, 1 no-device, 2 fp-pending, 3 protection, 4 alignment |

## Verification
Every output is due exactly one clock after its inputs are sampled, because the path from inputs to outputs is a single register stage. The bench changes its inputs on a falling edge and holds them through the next rising edge. It then compares all outputs at the falling edge that follows, against a behavioural model evaluated on those same held inputs. Reset is checked the same way: the comparison is made one falling edge after a rising edge at which `rst` was high.

// File: rtl/psat_pkg.sv
package psat_pkg;

  localparam int NUM_FAULTS  = 5;
  localparam int FI_ILLEGAL  = 0;
  localparam int FI_NODEV    = 1;
  localparam int FI_FPPEND   = 2;
  localparam int FI_PROT     = 3;
  localparam int FI_ALIGN    = 4;

  typedef struct packed {
    logic valid;
    logic lane_word;
    logic wide;
  } dec_t;

endpackage

// File: rtl/psat_decode.sv
module psat_decode
  import psat_pkg::*;
#(
  parameter logic [7:0] OPC_BYTE_LANES = 8'hDC,
  parameter logic [7:0] OPC_WORD_LANES = 8'hDD
) (
  input  logic [7:0] op_byte,
  input  logic       pfx_opsize,
  output dec_t       dec
);

  logic hit_byte;
  logic hit_word;

  always_comb begin
    hit_byte      = (op_byte == OPC_BYTE_LANES);
    hit_word      = (op_byte == OPC_WORD_LANES);
    dec.valid     = hit_byte | hit_word;
    dec.lane_word = hit_word;
    dec.wide      = (hit_byte | hit_word) & pfx_opsize;
  end

endmodule

// File: rtl/psat_fault_eval.sv
module psat_fault_eval
  import psat_pkg::*;
#(
  parameter int ADDR_LO_W    = 4,
  parameter int WIDE_BYTES   = 16,
  parameter int NARROW_BYTES = 8,
  parameter int CPL_W        = 2,
  parameter int USER_CPL     = 3
) (
  input  dec_t                  dec,
  input  logic                  pfx_lock,
  input  logic                  ctl_lazy_fp,
  input  logic                  ctl_emulate,
  input  logic                  ctl_ext_state,
  input  logic                  cap_wide_simd,
  input  logic                  align_chk_en,
  input  logic [CPL_W-1:0]      cpl,
  input  logic                  fp_exc_pend,
  input  logic                  mem_op,
  input  logic [ADDR_LO_W-1:0]  addr_lo,
  output logic [NUM_FAULTS-1:0] raw
);

  localparam logic [ADDR_LO_W-1:0] WIDE_MASK   = ADDR_LO_W'(WIDE_BYTES - 1);
  localparam logic [ADDR_LO_W-1:0] NARROW_MASK = ADDR_LO_W'(NARROW_BYTES - 1);

  logic misal_wide;
  logic misal_narrow;
  logic [NUM_FAULTS-1:0] cond;

  always_comb begin
    misal_wide   = |(addr_lo & WIDE_MASK);
    misal_narrow = |(addr_lo & NARROW_MASK);

    cond               = '0;
    cond[FI_ILLEGAL]   = ctl_emulate | pfx_lock |
                         (dec.wide & (~ctl_ext_state | ~cap_wide_simd));
    cond[FI_NODEV]     = ctl_lazy_fp;
    cond[FI_FPPEND]    = ~dec.wide & fp_exc_pend;
    cond[FI_PROT]      = dec.wide & mem_op & misal_wide;
    cond[FI_ALIGN]     = ~dec.wide & mem_op & align_chk_en &
                         (cpl == CPL_W'(USER_CPL)) & misal_narrow;

    raw = cond & {NUM_FAULTS{dec.valid}};
  end

endmodule

// File: rtl/psat_prio_pick.sv
module psat_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

endmodule

// File: rtl/psat_issue_check.sv
module psat_issue_check
  import psat_pkg::*;
#(
  parameter logic [7:0] OPC_BYTE_LANES = 8'hDC,
  parameter logic [7:0] OPC_WORD_LANES = 8'hDD,
  parameter int         ADDR_LO_W      = 4,
  parameter int         WIDE_BYTES     = 16,
  parameter int         NARROW_BYTES   = 8,
  parameter int         CPL_W          = 2,
  parameter int         USER_CPL       = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            op_byte,
  input  logic                  pfx_opsize,
  input  logic                  pfx_lock,
  input  logic                  ctl_lazy_fp,
  input  logic                  ctl_emulate,
  input  logic                  ctl_ext_state,
  input  logic                  cap_wide_simd,
  input  logic                  align_chk_en,
  input  logic [CPL_W-1:0]      cpl,
  input  logic                  fp_exc_pend,
  input  logic                  mem_op,
  input  logic [ADDR_LO_W-1:0]  addr_lo,
  output logic                  op_valid,
  output logic                  lane_word,
  output logic                  width_wide,
  output logic [NUM_FAULTS-1:0] fault
);

  dec_t                  dec;
  logic [NUM_FAULTS-1:0] raw_flt;
  logic [NUM_FAULTS-1:0] pick_flt;

  psat_decode #(
    .OPC_BYTE_LANES (OPC_BYTE_LANES),
    .OPC_WORD_LANES (OPC_WORD_LANES)
  ) u_decode (
    .op_byte    (op_byte),
    .pfx_opsize (pfx_opsize),
    .dec        (dec)
  );

  psat_fault_eval #(
    .ADDR_LO_W    (ADDR_LO_W),
    .WIDE_BYTES   (WIDE_BYTES),
    .NARROW_BYTES (NARROW_BYTES),
    .CPL_W        (CPL_W),
    .USER_CPL     (USER_CPL)
  ) u_eval (
    .dec           (dec),
    .pfx_lock      (pfx_lock),
    .ctl_lazy_fp   (ctl_lazy_fp),
    .ctl_emulate   (ctl_emulate),
    .ctl_ext_state (ctl_ext_state),
    .cap_wide_simd (cap_wide_simd),
    .align_chk_en  (align_chk_en),
    .cpl           (cpl),
    .fp_exc_pend   (fp_exc_pend),
    .mem_op        (mem_op),
    .addr_lo       (addr_lo),
    .raw           (raw_flt)
  );

  psat_prio_pick #(
    .N (NUM_FAULTS)
  ) u_pick (
    .req   (raw_flt),
    .grant (pick_flt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid   <= 1'b0;
      lane_word  <= 1'b0;
      width_wide <= 1'b0;
      fault      <= '0;
    end else begin
      op_valid   <= dec.valid;
      lane_word  <= dec.lane_word;
      width_wide <= dec.wide;
      fault      <= pick_flt;
    end
  end

  // Checks relating sampled inputs to the registered outputs one clock later
  logic ours;
  assign ours = (op_byte == OPC_BYTE_LANES) || (op_byte == OPC_WORD_LANES);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!op_valid && fault == '0 && !lane_word && !width_wide)); // R1
  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (rst)
    (op_byte == OPC_BYTE_LANES) |=> (op_valid && !lane_word)); // R2
  AST_WORD_LANES: assert property (@(posedge clk) disable iff (rst)
    (op_byte == OPC_WORD_LANES) |=> (op_valid && lane_word)); // R2
  AST_WIDTH_FOLLOWS_PFX: assert property (@(posedge clk) disable iff (rst)
    ours |=> (width_wide == $past(pfx_opsize))); // R3
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ours |=> (!op_valid && fault == '0)); // R4
  AST_LOCK_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (ours && (pfx_lock || ctl_emulate)) |=> fault[FI_ILLEGAL]); // R5
  AST_WIDE_UNSUPPORTED: assert property (@(posedge clk) disable iff (rst)
    (ours && pfx_opsize && (!ctl_ext_state || !cap_wide_simd)) |=> fault[FI_ILLEGAL]); // R6
  AST_LAZY_FP: assert property (@(posedge clk) disable iff (rst)
    (ours && ctl_lazy_fp) |=> (fault[FI_NODEV] || fault[FI_ILLEGAL])); // R7
  AST_WIDE_NO_FP: assert property (@(posedge clk) disable iff (rst)
    pfx_opsize |=> !fault[FI_FPPEND]); // R8
  AST_NARROW_NO_PROT: assert property (@(posedge clk) disable iff (rst)
    (!pfx_opsize || !mem_op) |=> !fault[FI_PROT]); // R9
  AST_WIDE_NO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    pfx_opsize |=> !fault[FI_ALIGN]); // R10
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault)); // R11

endmodule

// File: tb/tb_psat_issue_check.sv
module tb_psat_issue_check;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] op_byte;
  logic       pfx_opsize, pfx_lock, ctl_lazy_fp, ctl_emulate;
  logic       ctl_ext_state, cap_wide_simd, align_chk_en;
  logic [1:0] cpl;
  logic       fp_exc_pend, mem_op;
  logic [3:0] addr_lo;
  logic       op_valid, lane_word, width_wide;
  logic [4:0] fault;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  psat_issue_check dut (
    .clk (clk), .rst (rst), .op_byte (op_byte), .pfx_opsize (pfx_opsize),
    .pfx_lock (pfx_lock), .ctl_lazy_fp (ctl_lazy_fp), .ctl_emulate (ctl_emulate),
    .ctl_ext_state (ctl_ext_state), .cap_wide_simd (cap_wide_simd),
    .align_chk_en (align_chk_en), .cpl (cpl), .fp_exc_pend (fp_exc_pend),
    .mem_op (mem_op), .addr_lo (addr_lo), .op_valid (op_valid),
    .lane_word (lane_word), .width_wide (width_wide), .fault (fault)
  );

  // Behavioural model: {valid, lane, wide, fault[4:0]}
  function automatic logic [7:0] model();
    logic       v, l, w;
    logic [4:0] f;
    v = (op_byte == 8'hDC) || (op_byte == 8'hDD);
    l = 0; w = 0; f = 0;
    if (v) begin
      l = (op_byte == 8'hDD);
      w = pfx_opsize;
      if (ctl_emulate || pfx_lock || (w && (!ctl_ext_state || !cap_wide_simd)))
        f = 5'b00001;
      else if (ctl_lazy_fp)
        f = 5'b00010;
      else if (!w && fp_exc_pend)
        f = 5'b00100;
      else if (w && mem_op && (addr_lo % 16 != 0))
        f = 5'b01000;
      else if (!w && mem_op && align_chk_en && cpl == 2'd3 && (addr_lo % 8 != 0))
        f = 5'b10000;
    end
    return {v, l, w, f};
  endfunction

  task automatic benign(input logic [7:0] op, input logic wide);
    op_byte = op; pfx_opsize = wide; pfx_lock = 0; ctl_lazy_fp = 0;
    ctl_emulate = 0; ctl_ext_state = 1; cap_wide_simd = 1; align_chk_en = 0;
    cpl = 2'd0; fp_exc_pend = 0; mem_op = 0; addr_lo = 4'd0;
  endtask

  task automatic compare(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    got = {op_valid, lane_word, width_wide, fault};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got v=%0b l=%0b w=%0b f=%05b expected v=%0b l=%0b w=%0b f=%05b",
               tag, got[7], got[6], got[5], got[4:0], exp[7], exp[6], exp[5], exp[4:0]);
    end
  endtask

  // Inputs are already set at a falling edge; result due after one rising edge
  task automatic run(input string tag);
    logic [7:0] exp;
    exp = model();
    @(posedge clk);
    @(negedge clk);
    compare(tag, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1;
    benign(8'hDD, 1'b1);
    ctl_lazy_fp = 1;
    @(posedge clk); @(negedge clk);
    compare("R1", 8'h00);                       // R1 reset clears despite active inputs
    rst = 0;

    benign(8'hDC, 0); run("R2");                // R2 byte lanes, 64-bit
    benign(8'hDD, 0); run("R2");                // R2 word lanes
    benign(8'hDD, 1); run("R3");                // R3 wide
    benign(8'hDC, 1); mem_op = 1; run("R3");    // R3 aligned wide memory
    benign(8'h00, 1); pfx_lock = 1; ctl_lazy_fp = 1; run("R4");   // R4 unknown opcode
    benign(8'hDE, 0); ctl_emulate = 1; run("R4");                 // R4
    benign(8'hDC, 0); pfx_lock = 1; run("R5");                    // R5
    benign(8'hDD, 1); ctl_emulate = 1; run("R5");                 // R5
    benign(8'hDC, 1); ctl_ext_state = 0; run("R6");               // R6
    benign(8'hDD, 1); cap_wide_simd = 0; run("R6");               // R6
    benign(8'hDC, 0); ctl_ext_state = 0; cap_wide_simd = 0; run("R6"); // R6 ignored narrow
    benign(8'hDD, 0); ctl_lazy_fp = 1; run("R7");                 // R7
    benign(8'hDC, 0); fp_exc_pend = 1; run("R8");                 // R8
    benign(8'hDC, 1); fp_exc_pend = 1; run("R8");                 // R8 wide ignores
    benign(8'hDD, 1); mem_op = 1; addr_lo = 4'd8; run("R9");      // R9
    benign(8'hDD, 1); addr_lo = 4'd3; run("R9");                  // R9 register operand
    benign(8'hDD, 0); mem_op = 1; addr_lo = 4'd4; run("R9");      // R9 narrow no prot
    benign(8'hDC, 0); mem_op = 1; align_chk_en = 1; cpl = 3; addr_lo = 4'd4; run("R10");
    benign(8'hDC, 0); mem_op = 1; align_chk_en = 1; cpl = 3; addr_lo = 4'd8; run("R10");
    benign(8'hDC, 0); mem_op = 1; align_chk_en = 1; cpl = 2; addr_lo = 4'd1; run("R10");
    benign(8'hDC, 0); mem_op = 1; align_chk_en = 0; cpl = 3; addr_lo = 4'd1; run("R10");
    benign(8'hDC, 0); pfx_lock = 1; ctl_lazy_fp = 1; fp_exc_pend = 1; run("R11");
    benign(8'hDC, 0); ctl_lazy_fp = 1; fp_exc_pend = 1; run("R11");
    benign(8'hDC, 0); fp_exc_pend = 1; mem_op = 1; align_chk_en = 1; cpl = 3;
    addr_lo = 4'd2; run("R11");
    benign(8'hDD, 1); ctl_lazy_fp = 1; mem_op = 1; addr_lo = 4'd1; run("R11");

    for (int i = 0; i < 600; i++) begin
      int sel;
      sel = int'($urandom_range(0, 3));
      op_byte = (sel == 0) ? 8'($urandom) : ((sel == 1) ? 8'hDC : 8'hDD);
      pfx_opsize = 1'($urandom); pfx_lock = ($urandom_range(0, 7) == 0);
      ctl_lazy_fp = ($urandom_range(0, 5) == 0); ctl_emulate = ($urandom_range(0, 7) == 0);
      ctl_ext_state = ($urandom_range(0, 5) != 0); cap_wide_simd = ($urandom_range(0, 5) != 0);
      align_chk_en = 1'($urandom); cpl = 2'($urandom); fp_exc_pend = ($urandom_range(0, 3) == 0);
      mem_op = 1'($urandom); addr_lo = 4'($urandom);
      run("R11");
    end

    rst = 1; benign(8'hDC, 0);
    @(posedge clk); @(negedge clk);
    compare("R1", 8'h00);                       // R1 mid-run reset

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule